// File: doc/BRIEF.md
# Opcode-Controlled Multiply-Add Slice

This block is a pipelined signed arithmetic slice. It multiplies two 18-bit two's-complement operands. It then adds the 36-bit product, sign-extended to 48 bits, to one of several 48-bit operands, or subtracts it from that operand. A 7-bit opcode picks the operand on every cycle, so one slice can switch between these uses from one cycle to the next:

- starting a fresh sum from zero,
- accumulating into its own result,
- adding an external constant or offset,
- adding the result of a neighbouring slice on a cascade path,
- adding its own result shifted arithmetically right by 17 bits, which lets several products be stitched into a wider multiply.

A carry-in bit and a subtract bit complete the post-adder. The carry-in together with a constant operand gives symmetric rounding of a product to its upper bits.

The operand inputs pass through 0, 1 or 2 register stages, set by `A_STAGES` and `B_STAGES`. The product then passes through an optional register, set by `M_STAGES`. The opcode, subtract bit, carry-in and constant operand travel through a control pipeline of matching depth. A caller therefore presents every input in the same cycle and sees the result `max(A_STAGES,B_STAGES)+M_STAGES+1` rising edges later. The cascade operand is the one exception: it is sampled directly in the cycle the product reaches the adder, so that a chained neighbour's output can feed it. The cascade output is a copy of the result register. All registers use a synchronous, active-high reset.

Top module: `mac_slice`

## Requirements
- R1: With opcode 0x05 (operand field bits [6:4] = 000, multiplier field bits [3:0] = 0101), the result becomes the signed 18x18 product, sign-extended to 48 bits, plus the carry-in.
- R2: With opcode 0x25 (operand field 010), the result becomes the previous result plus the product plus the carry-in.
- R3: With opcode 0x35 (operand field 011), the result becomes the constant input plus the product plus the carry-in. The constant is taken in the same cycle as the multiplier operands.
- R4: With opcode 0x15 (operand field 001), the result becomes the cascade input plus the product plus the carry-in. The cascade input is sampled at the edge that loads the result.
- R5: With opcode 0x55 (operand field 101), the result becomes the previous result shifted arithmetically right by 17 bits, plus the product plus the carry-in.
- R6: If the multiplier field is not 0101, the product term is zero. Opcode 0x20 with carry-in 0 therefore holds the result unchanged, whatever the multiplier operands are. The undefined operand-field codes 100, 110 and 111 select zero.
- R7: With the subtract bit at 1, the result becomes the selected operand minus the sum of the product and the carry-in.
- R8: With opcode 0x35, a constant of 0x7FFF and a carry-in equal to the inverse of the XOR of the two operand sign bits, bits [35:16] of the result give the product rounded to the nearest integer, with ties rounded away from zero.
- R9: Synchronous reset clears the result and every pipeline register, whatever the opcode. No operation already in flight when reset is asserted reaches the result after reset is released.
- R10: With the default parameters (one stage on each operand, product register on), a result appears on the third rising edge after its inputs are applied. The cascade output always equals the result.
- R11: A sum beyond 48 bits wraps in two's complement, with no saturation.
- R12: Operations issued in consecutive cycles each take effect on consecutive edges. An accumulate that immediately follows a load sees the loaded value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 18 | Signed multiplier operand A |
| b_in | input | 18 | Signed multiplier operand B |
| c_in | input | 48 | Constant operand, pipelined with A and B |
| pc_in | input | 48 | Cascade operand from a neighbouring slice |
| opcode | input | 7 | Operand select [6:4], multiplier enable [3:0] |
| sub | input | 1 | 1 subtracts product and carry from the operand |
| cin | input | 1 | Carry-in to the post-adder |
| p_out | output | 48 | Registered result |
| pc_out | output | 48 | Cascade output, equal to p_out |

## Verification
Two functions can collide in one edge. The first is reset against an accumulate whose product is already in the pipeline. The test loads a known value and issues an accumulate. It then raises reset while that accumulate sits in the product stage. The result is judged zero at once, and it must still be zero several cycles after reset is released, which shows the flushed operation never lands. The second is a load followed by an accumulate on the very next edge. It is judged by sampling the result after each of the two edges, so the accumulate must see the value the load has just written.

// File: rtl/mac_slice_pkg.sv
package mac_slice_pkg;

    parameter int A_W     = 18;
    parameter int B_W     = 18;
    parameter int P_W     = 48;
    parameter int OP_W    = 7;
    parameter int SHR_AMT = 17;

    localparam int PROD_W = A_W + B_W;

    // operand select field, opcode[6:4]
    typedef enum logic [2:0] {
        ZS_ZERO = 3'b000,
        ZS_CASC = 3'b001,
        ZS_FB   = 3'b010,
        ZS_C    = 3'b011,
        ZS_SHR  = 3'b101
    } zsel_e;

    // multiplier-enable field, opcode[3:0]
    localparam logic [3:0] XY_MULT = 4'b0101;

    typedef struct packed {
        zsel_e            zsel;
        logic             use_prod;
        logic             sub;
        logic             cin;
        logic [P_W-1:0]   c;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

endpackage

// File: rtl/mac_delay_line.sv
module mac_delay_line #(
    parameter int W     = 8,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (DEPTH == 0) begin : g_pass
            assign q = d;
        end else begin : g_pipe
            logic [W-1:0] stage_d [DEPTH];
            logic [W-1:0] stage_q [DEPTH];

            always_comb begin
                stage_d[0] = d;
                for (int i = 1; i < DEPTH; i++) begin
                    stage_d[i] = stage_q[i-1];
                end
            end

            always_ff @(posedge clk) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (rst) begin
                        stage_q[i] <= '0;
                    end else begin
                        stage_q[i] <= stage_d[i];
                    end
                end
            end

            assign q = stage_q[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/mac_mult_stage.sv
module mac_mult_stage
    import mac_slice_pkg::*;
#(
    parameter int M_STAGES = 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [A_W-1:0] a,
    input  logic [B_W-1:0] b,
    output logic [P_W-1:0] prod_ext
);

    typedef struct packed {
        logic [P_W-1:0] prod;
    } mul_t;

    logic signed [PROD_W-1:0] prod_full;
    mul_t                     mul_d;

    always_comb begin
        prod_full  = $signed(a) * $signed(b);
        mul_d.prod = {{(P_W-PROD_W){prod_full[PROD_W-1]}}, prod_full};
    end

    generate
        if (M_STAGES == 0) begin : g_comb
            assign prod_ext = mul_d.prod;
        end else begin : g_reg
            mul_t mul_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    mul_q <= '0;
                end else begin
                    mul_q <= mul_d;
                end
            end
            assign prod_ext = mul_q.prod;
        end
    endgenerate

endmodule

// File: rtl/mac_post_add.sv
module mac_post_add
    import mac_slice_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  ctl_t           ctl,
    input  logic [P_W-1:0] prod_ext,
    input  logic [P_W-1:0] pc_in,
    output logic [P_W-1:0] p_q
);

    typedef struct packed {
        logic [P_W-1:0] p;
    } acc_t;

    acc_t                  acc_d;
    acc_t                  acc_q;
    logic [P_W-1:0]        z_op;
    logic [P_W-1:0]        x_op;
    logic [P_W-1:0]        addend;
    logic signed [P_W-1:0] p_signed;

    always_comb begin
        p_signed = acc_q.p;
        case (ctl.zsel)
            ZS_ZERO: z_op = '0;
            ZS_CASC: z_op = pc_in;
            ZS_FB:   z_op = acc_q.p;
            ZS_C:    z_op = ctl.c;
            ZS_SHR:  z_op = p_signed >>> SHR_AMT;
            default: z_op = '0;
        endcase
        x_op   = ctl.use_prod ? prod_ext : '0;
        addend = x_op + {{(P_W-1){1'b0}}, ctl.cin};
        acc_d.p = ctl.sub ? (z_op - addend) : (z_op + addend);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign p_q = acc_q.p;

endmodule

// File: rtl/mac_slice.sv
module mac_slice
    import mac_slice_pkg::*;
#(
    parameter int A_STAGES = 1,
    parameter int B_STAGES = 1,
    parameter int M_STAGES = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [A_W-1:0]  a_in,
    input  logic [B_W-1:0]  b_in,
    input  logic [P_W-1:0]  c_in,
    input  logic [P_W-1:0]  pc_in,
    input  logic [OP_W-1:0] opcode,
    input  logic            sub,
    input  logic            cin,
    output logic [P_W-1:0]  p_out,
    output logic [P_W-1:0]  pc_out
);

    localparam int IN_STAGES  = (A_STAGES > B_STAGES) ? A_STAGES : B_STAGES;
    localparam int CTL_STAGES = IN_STAGES + M_STAGES;

    logic [A_W-1:0]   a_pipe;
    logic [B_W-1:0]   b_pipe;
    logic [P_W-1:0]   prod_ext;
    ctl_t             ctl_in;
    logic [CTL_W-1:0] ctl_vec;
    ctl_t             ctl_add;

    always_comb begin
        ctl_in.zsel     = zsel_e'(opcode[6:4]);
        ctl_in.use_prod = (opcode[3:0] == XY_MULT);
        ctl_in.sub      = sub;
        ctl_in.cin      = cin;
        ctl_in.c        = c_in;
    end

    mac_delay_line #(.W(A_W), .DEPTH(A_STAGES)) u_a_pipe (
        .clk(clk), .rst(rst), .d(a_in), .q(a_pipe)
    );

    mac_delay_line #(.W(B_W), .DEPTH(B_STAGES)) u_b_pipe (
        .clk(clk), .rst(rst), .d(b_in), .q(b_pipe)
    );

    mac_delay_line #(.W(CTL_W), .DEPTH(CTL_STAGES)) u_ctl_pipe (
        .clk(clk), .rst(rst), .d(ctl_in), .q(ctl_vec)
    );

    assign ctl_add = ctl_t'(ctl_vec);

    mac_mult_stage #(.M_STAGES(M_STAGES)) u_mult (
        .clk(clk), .rst(rst), .a(a_pipe), .b(b_pipe), .prod_ext(prod_ext)
    );

    mac_post_add u_add (
        .clk(clk), .rst(rst), .ctl(ctl_add), .prod_ext(prod_ext),
        .pc_in(pc_in), .p_q(p_out)
    );

    assign pc_out = p_out;

endmodule

// File: rtl/mac_slice_chk.sv
module mac_slice_chk
    import mac_slice_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic [P_W-1:0] p,
    input ctl_t           ctl,
    input logic [P_W-1:0] prod,
    input logic [P_W-1:0] pc_in
);

    // R9
    p_reset_clear_chk: assert property (@(posedge clk)
        rst |=> (p == '0));

    // R6
    p_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.zsel == ZS_FB && !ctl.use_prod && !ctl.cin) |=> (p == $past(p)));

    // R3
    c_add_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.zsel == ZS_C && ctl.use_prod && !ctl.sub)
        |=> (p == $past(ctl.c) + $past(prod) + {{(P_W-1){1'b0}}, $past(ctl.cin)}));

    // R4
    casc_add_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.zsel == ZS_CASC && ctl.use_prod && !ctl.sub)
        |=> (p == $past(pc_in) + $past(prod) + {{(P_W-1){1'b0}}, $past(ctl.cin)}));

    // R7
    zero_sub_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.zsel == ZS_ZERO && ctl.use_prod && ctl.sub)
        |=> (p == '0 - $past(prod) - {{(P_W-1){1'b0}}, $past(ctl.cin)}));

endmodule

bind mac_slice mac_slice_chk u_chk (
    .clk(clk), .rst(rst), .p(p_out), .ctl(ctl_add), .prod(prod_ext), .pc_in(pc_in)
);

// File: tb/mac_slice_tb.sv
module mac_slice_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [17:0] a_in = '0;
    logic [17:0] b_in = '0;
    logic [47:0] c_in = '0;
    logic [47:0] pc_in = '0;
    logic [6:0]  opcode = 7'h20;
    logic        sub = 1'b0;
    logic        cin = 1'b0;
    logic [47:0] p_out;
    logic [47:0] pc_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mac_slice u_dut (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .c_in(c_in),
        .pc_in(pc_in), .opcode(opcode), .sub(sub), .cin(cin),
        .p_out(p_out), .pc_out(pc_out)
    );

    task automatic check(input string tag, input logic [47:0] got, input logic [47:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic drive(input longint a, input longint b, input logic [47:0] c,
                         input logic [6:0] op, input logic s, input logic ci);
        a_in   = a[17:0];
        b_in   = b[17:0];
        c_in   = c;
        opcode = op;
        sub    = s;
        cin    = ci;
    endtask

    task automatic drive_idle();
        opcode = 7'h20;
        sub    = 1'b0;
        cin    = 1'b0;
        a_in   = 18'h15555;
        b_in   = 18'h0AAAA;
    endtask

    // one operation, result sampled after the third edge
    task automatic run_op(input longint a, input longint b, input logic [47:0] c,
                          input logic [6:0] op, input logic s, input logic ci);
        @(negedge clk);
        drive(a, b, c, op, s, ci);
        @(negedge clk);
        drive_idle();
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [47:0] w48(input longint v);
        return v[47:0];
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R9 reset result", p_out, 48'h0);
        check("R10 reset cascade out", pc_out, 48'h0);
        rst = 1'b0;
    endtask

    task automatic t_load();
        run_op(-5, 7, 48'h0, 7'h05, 1'b0, 1'b0);
        check("R1 load product", p_out, w48(-35));
        check("R10 cascade equals result", pc_out, w48(-35));
        run_op(-7, -9, 48'h0, 7'h05, 1'b0, 1'b1);
        check("R1 load product with carry", p_out, w48(64));
    endtask

    task automatic t_accum();
        run_op(-5, 7, 48'h0, 7'h05, 1'b0, 1'b0);
        run_op(100, 200, 48'h0, 7'h25, 1'b0, 1'b0);
        check("R2 accumulate", p_out, w48(-35 + 20000));
        run_op(-131072, 131071, 48'h0, 7'h25, 1'b0, 1'b0);
        check("R2 accumulate extreme product", p_out, w48(19965 + (-131072 * 131071)));
    endtask

    task automatic t_cadd();
        run_op(3, -4, w48(1000000), 7'h35, 1'b0, 1'b0);
        check("R3 constant plus product", p_out, w48(999988));
    endtask

    task automatic t_casc();
        pc_in = w48(-500);
        run_op(10, 10, 48'h0, 7'h15, 1'b0, 1'b0);
        check("R4 cascade plus product", p_out, w48(-400));
        pc_in = '0;
    endtask

    task automatic t_shift();
        run_op(0, 0, w48(-(64'sd1 <<< 40)), 7'h35, 1'b0, 1'b0);
        run_op(2, 3, 48'h0, 7'h55, 1'b0, 1'b0);
        check("R5 shifted result plus product", p_out, w48(-(64'sd1 <<< 23) + 6));
    endtask

    task automatic t_nomult();
        run_op(0, 0, w48(12345), 7'h35, 1'b0, 1'b0);
        run_op(50, 50, 48'h0, 7'h20, 1'b0, 1'b0);
        check("R6 hold ignores operands", p_out, w48(12345));
        run_op(50, 50, w48(77), 7'h30, 1'b0, 1'b0);
        check("R6 constant without product", p_out, w48(77));
        run_op(4, 4, w48(999), 7'h75, 1'b0, 1'b0);
        check("R6 undefined field selects zero", p_out, w48(16));
    endtask

    task automatic t_sub();
        run_op(0, 0, w48(1000), 7'h35, 1'b0, 1'b0);
        run_op(6, 7, 48'h0, 7'h25, 1'b1, 1'b1);
        check("R7 subtract product and carry", p_out, w48(957));
        run_op(6, 7, 48'h0, 7'h05, 1'b1, 1'b0);
        check("R7 zero minus product", p_out, w48(-42));
    endtask

    function automatic longint sym_round(input longint prod);
        longint mag = (prod < 0) ? -prod : prod;
        longint r   = (mag + 32768) >>> 16;
        return (prod < 0) ? -r : r;
    endfunction

    task automatic round_case(input longint a, input longint b);
        logic ci;
        longint expv;
        logic [19:0] exp20;
        ci = ~(a[17] ^ b[17]);
        run_op(a, b, w48(32767), 7'h35, 1'b0, ci);
        expv  = sym_round(a * b);
        exp20 = expv[19:0];
        check("R8 symmetric rounding", {28'h0, p_out[35:16]}, {28'h0, exp20});
    endtask

    task automatic t_round();
        round_case(3, 32768);
        round_case(-3, 32768);
        round_case(1000, -100);
        round_case(-77777, -12345);
    endtask

    task automatic t_wrap();
        run_op(1, 1, 48'h7FFF_FFFF_FFFF, 7'h35, 1'b0, 1'b0);
        check("R11 wrap past maximum", p_out, 48'h8000_0000_0000);
    endtask

    task automatic t_latency();
        run_op(0, 0, w48(5), 7'h35, 1'b0, 1'b0);
        @(negedge clk);
        drive(9, 9, 48'h0, 7'h05, 1'b0, 1'b0);
        @(negedge clk);
        drive_idle();
        @(posedge clk);
        @(negedge clk);
        check("R10 not yet after two edges", p_out, w48(5));
        @(posedge clk);
        @(negedge clk);
        check("R10 result after third edge", p_out, w48(81));
    endtask

    task automatic t_backtoback();
        @(negedge clk);
        drive(2, 3, 48'h0, 7'h05, 1'b0, 1'b0);
        @(negedge clk);
        drive(4, 5, 48'h0, 7'h25, 1'b0, 1'b0);
        @(negedge clk);
        drive_idle();
        @(posedge clk);
        @(negedge clk);
        check("R12 first of pair", p_out, w48(6));
        @(posedge clk);
        @(negedge clk);
        check("R12 accumulate sees load", p_out, w48(26));
    endtask

    task automatic t_reset_mid();
        run_op(0, 0, w48(500), 7'h35, 1'b0, 1'b0);
        @(negedge clk);
        drive(10, 10, 48'h0, 7'h25, 1'b0, 1'b0);
        @(negedge clk);
        drive_idle();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R9 reset wins over accumulate", p_out, 48'h0);
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R9 flushed operation never lands", p_out, 48'h0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_load();
        t_accum();
        t_cadd();
        t_casc();
        t_shift();
        t_nomult();
        t_sub();
        t_round();
        t_wrap();
        t_latency();
        t_backtoback();
        t_reset_mid();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule